// File: doc/BRIEF.md
# Parallel Bus Cycle Master with Wait-State Stretching

This block turns a single local request into one byte-wide read or write cycle on a parallel system bus. The local side offers an address, a memory-or-I/O choice, a direction and a write byte. The block then steps through a fixed sequence of bus clocks. It pulses an address-valid strobe in the first clock and drives one of four active-low command strobes: memory read, memory write, I/O read or I/O write. It returns the read byte with a one-clock completion pulse.

The addressed slave can lengthen a cycle by holding its ready input low. Each low sample adds one wait clock, up to a parameterised limit. When the limit is reached, the cycle completes anyway and a timeout indication is raised. Memory cycles carry the full address width. I/O cycles carry only the narrower I/O address, and the upper address lines are driven to zero.

Top module: `bus_cycle_master`

## Requirements
- R1: While the synchronous active-high reset is high, and in the clock after it, the block is idle. busy_o, done_o, bus_adv_o and bus_data_oe_o are 0, all four command strobes are 1, bus_addr_o is 0, and rdata_o and timeout_o are 0. A reset in the middle of a cycle abandons the cycle at once.
- R2: A cycle with ready sampled high has exactly four clocks, in this order: address clock, command clock, transfer clock and end clock. bus_adv_o is 1 only in the address clock. done_o is 1 only in the end clock.
- R3: The command strobe is chosen by the request. With memory select 1, a read uses bus_mrd_n_o and a write uses bus_mwr_n_o. With memory select 0, a read uses bus_iord_n_o and a write uses bus_iowr_n_o. The chosen strobe is 0 in the command clock, in every wait clock and in the transfer clock. It is 1 in the address clock and in the end clock. At most one strobe is ever 0.
- R4: bus_addr_o shows the accepted address from the address clock through the end clock and does not change during the cycle. No strobe is low while bus_adv_o is 1, so the address leads the strobe by one clock.
- R5: In an I/O cycle, bus_addr_o bits above IO_AW-1 are 0, whatever the request carried there.
- R6: bus_ready_i is sampled only at the end of the command clock and at the end of each wait clock. Each low sample inserts one wait clock before the transfer clock. Its value in any other clock has no effect.
- R7: After MAX_WAIT wait clocks, the cycle proceeds to the transfer clock regardless of ready. In that case timeout_o is set on entry to the transfer clock and stays set until the next request is accepted. A cycle that ends within the limit leaves timeout_o at 0.
- R8: For a read, rdata_o takes the value of bus_data_i sampled at the end of the transfer clock. rdata_o keeps that value through later write cycles until the next read.
- R9: For a write, bus_data_oe_o is 1 and bus_data_o equals the write byte from the command clock through the end clock. Otherwise bus_data_oe_o is 0 and bus_data_o is 0.
- R10: A request is accepted only in an idle clock, and busy_o is 1 from the address clock through the end clock. Request inputs that change during a cycle have no effect on it. A request held high is accepted in the idle clock that follows done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid_i | input | 1 | Local request present |
| req_mem_i | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | MEM_AW | Request address |
| req_wdata_i | input | DW | Write byte |
| busy_o | output | 1 | Cycle in progress |
| done_o | output | 1 | One-clock completion pulse (end clock) |
| rdata_o | output | DW | Last read byte |
| timeout_o | output | 1 | Last cycle hit the wait limit |
| bus_addr_o | output | MEM_AW | Bus address |
| bus_adv_o | output | 1 | Address-valid strobe |
| bus_mrd_n_o | output | 1 | Memory read strobe, active low |
| bus_mwr_n_o | output | 1 | Memory write strobe, active low |
| bus_iord_n_o | output | 1 | I/O read strobe, active low |
| bus_iowr_n_o | output | 1 | I/O write strobe, active low |
| bus_data_o | output | DW | Write data to bus |
| bus_data_oe_o | output | 1 | Write data drive enable |
| bus_data_i | input | DW | Read data from bus |
| bus_ready_i | input | 1 | Slave ready; low requests a wait clock |

## Verification
The bench builds the block with its default parameters: a 20-bit memory address, a 16-bit I/O address, 8-bit data and a limit of six wait clocks. With a limit this small, a slave can stall exactly at the limit (six waits, no timeout) and one clock past it (forced completion with timeout), so both sides of the boundary are reached in a few clocks. The 16-bit I/O width leaves four upper address bits that the bench fills with ones in I/O requests. Ready and read data are made random outside their sampling clocks, which exposes any sampling in the wrong clock.

// File: rtl/bcm_pkg.sv
package bcm_pkg;

    // Bus cycle phases; order follows the cycle sequence.
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_ADDR = 3'd1,
        PH_CMD  = 3'd2,
        PH_WAIT = 3'd3,
        PH_XFER = 3'd4,
        PH_END  = 3'd5
    } phase_e;

    function automatic logic in_strobe_window(input phase_e ph);
        return (ph == PH_CMD) || (ph == PH_WAIT) || (ph == PH_XFER);
    endfunction

    function automatic logic in_wdata_window(input phase_e ph);
        return (ph == PH_CMD) || (ph == PH_WAIT) || (ph == PH_XFER) || (ph == PH_END);
    endfunction

endpackage

// File: rtl/bcm_sequencer.sv
module bcm_sequencer
    import bcm_pkg::*;
#(
    parameter int MAX_WAIT = 6
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   start_i,
    input  logic   ready_i,
    output phase_e phase_o,
    output logic   tmo_o
);

    localparam int WCNT_W = (MAX_WAIT < 1) ? 1 : $clog2(MAX_WAIT + 1);
    localparam logic [WCNT_W-1:0] WLIM = WCNT_W'(MAX_WAIT);
    localparam bit NO_WAIT = (MAX_WAIT == 0);

    typedef struct packed {
        phase_e            phase;
        logic [WCNT_W-1:0] wcnt;
        logic              tmo;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        case (seq_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    seq_d.phase = PH_ADDR;
                    seq_d.wcnt  = '0;
                    seq_d.tmo   = 1'b0;
                end
            end
            PH_ADDR: seq_d.phase = PH_CMD;
            PH_CMD: begin
                if (ready_i) begin
                    seq_d.phase = PH_XFER;
                end else if (NO_WAIT) begin
                    seq_d.phase = PH_XFER;
                    seq_d.tmo   = 1'b1;
                end else begin
                    seq_d.phase = PH_WAIT;
                    seq_d.wcnt  = WCNT_W'(1);
                end
            end
            PH_WAIT: begin
                if (ready_i) begin
                    seq_d.phase = PH_XFER;
                end else if (seq_q.wcnt == WLIM) begin
                    seq_d.phase = PH_XFER;
                    seq_d.tmo   = 1'b1;
                end else begin
                    seq_d.wcnt = seq_q.wcnt + WCNT_W'(1);
                end
            end
            PH_XFER: seq_d.phase = PH_END;
            PH_END:  seq_d.phase = PH_IDLE;
            default: seq_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q <= '{phase: PH_IDLE, wcnt: '0, tmo: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign phase_o = seq_q.phase;
    assign tmo_o   = seq_q.tmo;

    assert_wait_bound_R7: assert property (@(posedge clk) disable iff (rst)
        seq_q.wcnt <= WLIM);

    assert_addr_then_cmd_R2: assert property (@(posedge clk) disable iff (rst)
        seq_q.phase == PH_ADDR |=> seq_q.phase == PH_CMD);

    assert_xfer_then_end_R2: assert property (@(posedge clk) disable iff (rst)
        seq_q.phase == PH_XFER |=> seq_q.phase == PH_END);

    assert_end_then_idle_R2: assert property (@(posedge clk) disable iff (rst)
        seq_q.phase == PH_END |=> seq_q.phase == PH_IDLE);

    assert_wait_release_R6: assert property (@(posedge clk) disable iff (rst)
        (seq_q.phase == PH_WAIT && ready_i) |=> (seq_q.phase == PH_XFER && !seq_q.tmo));

    assert_limit_forces_xfer_R7: assert property (@(posedge clk) disable iff (rst)
        (seq_q.phase == PH_WAIT && !ready_i && seq_q.wcnt == WLIM) |=> (seq_q.phase == PH_XFER && seq_q.tmo));

endmodule

// File: rtl/bcm_datapath.sv
module bcm_datapath #(
    parameter int MEM_AW = 20,
    parameter int IO_AW  = 16,
    parameter int DW     = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              req_mem_i,
    input  logic              req_write_i,
    input  logic [MEM_AW-1:0] req_addr_i,
    input  logic [DW-1:0]     req_wdata_i,
    input  logic              capture_i,
    input  logic [DW-1:0]     bus_data_i,
    output logic              is_mem_o,
    output logic              is_write_o,
    output logic [MEM_AW-1:0] addr_o,
    output logic [DW-1:0]     wdata_o,
    output logic [DW-1:0]     rdata_o
);

    localparam logic [MEM_AW-1:0] IO_MASK = MEM_AW'({IO_AW{1'b1}});

    typedef struct packed {
        logic              is_mem;
        logic              is_write;
        logic [MEM_AW-1:0] addr;
        logic [DW-1:0]     wdata;
        logic [DW-1:0]     rdata;
    } dp_t;

    dp_t dp_d, dp_q;

    always_comb begin
        dp_d = dp_q;
        if (start_i) begin
            dp_d.is_mem   = req_mem_i;
            dp_d.is_write = req_write_i;
            dp_d.addr     = req_mem_i ? req_addr_i : (req_addr_i & IO_MASK);
            dp_d.wdata    = req_wdata_i;
        end
        if (capture_i) begin
            dp_d.rdata = bus_data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign is_mem_o   = dp_q.is_mem;
    assign is_write_o = dp_q.is_write;
    assign addr_o     = dp_q.addr;
    assign wdata_o    = dp_q.wdata;
    assign rdata_o    = dp_q.rdata;

    assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !capture_i |=> $stable(dp_q.rdata));

endmodule

// File: rtl/bcm_strobe_dec.sv
module bcm_strobe_dec
    import bcm_pkg::*;
(
    input  phase_e phase_i,
    input  logic   is_mem_i,
    input  logic   is_write_i,
    output logic   adv_o,
    output logic   mrd_n_o,
    output logic   mwr_n_o,
    output logic   iord_n_o,
    output logic   iowr_n_o,
    output logic   data_oe_o,
    output logic   busy_o,
    output logic   done_o
);

    logic win;

    always_comb begin
        win       = in_strobe_window(phase_i);
        adv_o     = (phase_i == PH_ADDR);
        busy_o    = (phase_i != PH_IDLE);
        done_o    = (phase_i == PH_END);
        mrd_n_o   = !(win &&  is_mem_i && !is_write_i);
        mwr_n_o   = !(win &&  is_mem_i &&  is_write_i);
        iord_n_o  = !(win && !is_mem_i && !is_write_i);
        iowr_n_o  = !(win && !is_mem_i &&  is_write_i);
        data_oe_o = is_write_i && in_wdata_window(phase_i);
    end

endmodule

// File: rtl/bus_cycle_master.sv
module bus_cycle_master
    import bcm_pkg::*;
#(
    parameter int MEM_AW   = 20,
    parameter int IO_AW    = 16,
    parameter int DW       = 8,
    parameter int MAX_WAIT = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid_i,
    input  logic              req_mem_i,
    input  logic              req_write_i,
    input  logic [MEM_AW-1:0] req_addr_i,
    input  logic [DW-1:0]     req_wdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [DW-1:0]     rdata_o,
    output logic              timeout_o,
    output logic [MEM_AW-1:0] bus_addr_o,
    output logic              bus_adv_o,
    output logic              bus_mrd_n_o,
    output logic              bus_mwr_n_o,
    output logic              bus_iord_n_o,
    output logic              bus_iowr_n_o,
    output logic [DW-1:0]     bus_data_o,
    output logic              bus_data_oe_o,
    input  logic [DW-1:0]     bus_data_i,
    input  logic              bus_ready_i
);

    phase_e            phase;
    logic              start;
    logic              capture;
    logic              is_mem;
    logic              is_write;
    logic [MEM_AW-1:0] addr;
    logic [DW-1:0]     wdata;

    assign start   = req_valid_i && (phase == PH_IDLE);
    assign capture = (phase == PH_XFER) && !is_write;

    bcm_sequencer #(.MAX_WAIT(MAX_WAIT)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start_i (start),
        .ready_i (bus_ready_i),
        .phase_o (phase),
        .tmo_o   (timeout_o)
    );

    bcm_datapath #(.MEM_AW(MEM_AW), .IO_AW(IO_AW), .DW(DW)) u_dp (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start),
        .req_mem_i   (req_mem_i),
        .req_write_i (req_write_i),
        .req_addr_i  (req_addr_i),
        .req_wdata_i (req_wdata_i),
        .capture_i   (capture),
        .bus_data_i  (bus_data_i),
        .is_mem_o    (is_mem),
        .is_write_o  (is_write),
        .addr_o      (addr),
        .wdata_o     (wdata),
        .rdata_o     (rdata_o)
    );

    bcm_strobe_dec u_dec (
        .phase_i    (phase),
        .is_mem_i   (is_mem),
        .is_write_i (is_write),
        .adv_o      (bus_adv_o),
        .mrd_n_o    (bus_mrd_n_o),
        .mwr_n_o    (bus_mwr_n_o),
        .iord_n_o   (bus_iord_n_o),
        .iowr_n_o   (bus_iowr_n_o),
        .data_oe_o  (bus_data_oe_o),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );

    assign bus_addr_o = busy_o ? addr : '0;
    assign bus_data_o = bus_data_oe_o ? wdata : '0;

    assert_one_strobe_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({!bus_mrd_n_o, !bus_mwr_n_o, !bus_iord_n_o, !bus_iowr_n_o}));

    assert_adv_before_strobe_R4: assert property (@(posedge clk) disable iff (rst)
        bus_adv_o |-> (bus_mrd_n_o && bus_mwr_n_o && bus_iord_n_o && bus_iowr_n_o));

    assert_addr_stable_R4: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |-> $stable(bus_addr_o));

    assert_done_releases_R10: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !busy_o);

    assert_strobe_in_window_R3: assert property (@(posedge clk) disable iff (rst)
        (!busy_o || bus_adv_o || done_o) |-> (bus_mrd_n_o && bus_mwr_n_o && bus_iord_n_o && bus_iowr_n_o));

    generate
        if (IO_AW < MEM_AW) begin : g_io_chk
            assert_io_upper_zero_R5: assert property (@(posedge clk) disable iff (rst)
                (busy_o && !is_mem) |-> (bus_addr_o[MEM_AW-1:IO_AW] == '0));
        end
    endgenerate

endmodule

// File: tb/bus_cycle_master_tb.sv
module bus_cycle_master_tb_top;

    localparam int MEM_AW = 20;
    localparam int IO_AW  = 16;
    localparam int DW     = 8;
    localparam int MAXW   = 6;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_mem = 1'b0;
    logic              req_write = 1'b0;
    logic [MEM_AW-1:0] req_addr = '0;
    logic [DW-1:0]     req_wdata = '0;
    logic              busy, done, timeout;
    logic [DW-1:0]     rdata;
    logic [MEM_AW-1:0] bus_addr;
    logic              adv, mrd_n, mwr_n, iord_n, iowr_n, data_oe;
    logic [DW-1:0]     bus_dout;
    logic [DW-1:0]     bus_din = '0;
    logic              ready = 1'b1;

    always #4 clk = ~clk;

    bus_cycle_master #(.MEM_AW(MEM_AW), .IO_AW(IO_AW), .DW(DW), .MAX_WAIT(MAXW)) dut_i (
        .clk (clk), .rst (rst),
        .req_valid_i (req_valid), .req_mem_i (req_mem), .req_write_i (req_write),
        .req_addr_i (req_addr), .req_wdata_i (req_wdata),
        .busy_o (busy), .done_o (done), .rdata_o (rdata), .timeout_o (timeout),
        .bus_addr_o (bus_addr), .bus_adv_o (adv),
        .bus_mrd_n_o (mrd_n), .bus_mwr_n_o (mwr_n), .bus_iord_n_o (iord_n), .bus_iowr_n_o (iowr_n),
        .bus_data_o (bus_dout), .bus_data_oe_o (data_oe),
        .bus_data_i (bus_din), .bus_ready_i (ready)
    );

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;
    bit started = 0;

    // Behavioural reference: 0 idle, 1 address, 2 command, 3 wait, 4 transfer, 5 end
    int              m_ph = 0;
    int              m_waits = 0;
    bit              m_tmo = 0;
    logic [DW-1:0]   m_rd = '0;
    bit              m_mem = 0;
    bit              m_wr = 0;
    logic [MEM_AW-1:0] m_addr = '0;
    logic [DW-1:0]   m_wd = '0;
    int              stall_left = 0;
    logic [DW-1:0]   rd_val = '0;

    always @(posedge clk) begin
        started <= 1'b1;
        if ((m_ph == 2 || m_ph == 3) && !ready && stall_left > 0) stall_left--;
        if (rst) begin
            m_ph = 0; m_waits = 0; m_tmo = 0; m_rd = '0;
            m_mem = 0; m_wr = 0; m_addr = '0; m_wd = '0;
        end else begin
            case (m_ph)
                0: if (req_valid) begin
                    m_mem = req_mem; m_wr = req_write; m_wd = req_wdata; m_tmo = 0;
                    m_addr = req_mem ? req_addr : (req_addr & 20'h0FFFF);
                    m_ph = 1;
                end
                1: m_ph = 2;
                2: if (ready) m_ph = 4; else begin m_ph = 3; m_waits = 1; end
                3: if (ready) m_ph = 4;
                   else if (m_waits == MAXW) begin m_ph = 4; m_tmo = 1; end
                   else m_waits++;
                4: begin if (!m_wr) m_rd = bus_din; m_ph = 5; end
                default: m_ph = 0;
            endcase
        end
    end

    task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s at %0t: actual %0h expected %0h", rq, what, $time, act, exp);
        end
    endtask

    // Compare every clock, then drive slave-side inputs.
    always @(negedge clk) begin
        if (started && !finished) begin
            bit win, e_oe, e_busy;
            win    = (m_ph >= 2 && m_ph <= 4);
            e_busy = (m_ph != 0);
            e_oe   = m_wr && (m_ph >= 2 && m_ph <= 5);
            chk("R10", "busy_o", 32'(busy), 32'(e_busy));
            chk("R2", "bus_adv_o", 32'(adv), 32'(m_ph == 1));
            chk("R2 R6", "done_o", 32'(done), 32'(m_ph == 5));
            chk("R3", "bus_mrd_n_o", 32'(mrd_n), 32'(!(win && m_mem && !m_wr)));
            chk("R3", "bus_mwr_n_o", 32'(mwr_n), 32'(!(win && m_mem && m_wr)));
            chk("R3", "bus_iord_n_o", 32'(iord_n), 32'(!(win && !m_mem && !m_wr)));
            chk("R3", "bus_iowr_n_o", 32'(iowr_n), 32'(!(win && !m_mem && m_wr)));
            chk("R4 R5", "bus_addr_o", 32'(bus_addr), e_busy ? 32'(m_addr) : 32'd0);
            chk("R9", "bus_data_oe_o", 32'(data_oe), 32'(e_oe));
            chk("R9", "bus_data_o", 32'(bus_dout), e_oe ? 32'(m_wd) : 32'd0);
            chk("R7", "timeout_o", 32'(timeout), 32'(m_tmo));
            chk("R8", "rdata_o", 32'(rdata), 32'(m_rd));
        end
        if (m_ph == 2 || m_ph == 3) ready = (stall_left == 0);
        else ready = 1'($urandom_range(0, 1));
        bus_din = (m_ph == 4) ? rd_val : DW'($urandom_range(0, 255));
    end

    task automatic run_cycle(input bit mem, input bit wr, input logic [MEM_AW-1:0] a,
                             input logic [DW-1:0] wd, input logic [DW-1:0] rd, input int stall);
        int len;
        int exp_w;
        @(negedge clk);
        req_valid = 1; req_mem = mem; req_write = wr; req_addr = a; req_wdata = wd;
        stall_left = stall; rd_val = rd;
        @(negedge clk);
        req_valid = 0;
        req_addr = ~a;            // changes while busy must not matter (R10)
        len = 0;
        while (m_ph != 0) begin len++; @(negedge clk); end
        exp_w = (stall > MAXW) ? MAXW : stall;
        chk("R6 R7", "cycle length", 32'(len), 32'(4 + exp_w));
        chk("R7", "timeout after cycle", 32'(timeout), 32'(stall > MAXW));
        if (!wr) chk("R8", "read byte", 32'(rdata), 32'(rd));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "reset strobes", 32'({mrd_n, mwr_n, iord_n, iowr_n}), 32'hF);
        chk("R1", "reset busy/adv/oe", 32'({busy, adv, data_oe, done}), 32'h0);
        rst = 0;
        @(negedge clk);
        chk("R1", "idle after reset", 32'({busy, timeout}), 32'h0);

        run_cycle(1, 0, 20'hA1234, 8'h00, 8'h5A, 0);   // R2 memory read, no wait
        run_cycle(1, 1, 20'h0BEEF, 8'hC3, 8'h00, 0);   // R9 memory write
        chk("R8", "rdata held across write", 32'(rdata), 32'h5A);
        run_cycle(0, 0, 20'hF2345, 8'h00, 8'h96, 2);   // R5 R6 I/O read, upper bits set
        run_cycle(0, 1, 20'hFFFFF, 8'h3C, 8'h00, 1);   // R5 I/O write
        run_cycle(1, 0, 20'h12345, 8'h00, 8'hE7, 6);   // R7 exactly at limit
        run_cycle(1, 1, 20'h54321, 8'h81, 8'h00, 7);   // R7 limit exceeded
        run_cycle(1, 0, 20'h00001, 8'h00, 8'h11, 20);  // R7 long stall, read
        run_cycle(0, 0, 20'h00010, 8'h00, 8'h22, 0);   // R7 timeout clears

        // R10: request held high; second accepted in idle clock after done
        @(negedge clk);
        req_valid = 1; req_mem = 1; req_write = 0; req_addr = 20'h11111; stall_left = 0; rd_val = 8'h44;
        while (m_ph != 5) @(negedge clk);
        req_addr = 20'h22222;
        @(negedge clk);
        chk("R10", "idle gap after done", 32'(busy), 32'h0);
        @(negedge clk);
        chk("R10", "held request accepted", 32'({adv, bus_addr}), 32'({1'b1, 20'h22222}));
        req_valid = 0;
        while (m_ph != 0) @(negedge clk);

        // R1: reset in the middle of a wait clock
        @(negedge clk);
        req_valid = 1; req_mem = 0; req_write = 1; req_addr = 20'h00777; req_wdata = 8'h99; stall_left = 5;
        @(negedge clk);
        req_valid = 0;
        while (m_ph != 3) @(negedge clk);
        rst = 1;
        @(negedge clk);
        chk("R1", "mid-cycle reset strobes", 32'({mrd_n, mwr_n, iord_n, iowr_n, busy, data_oe}), 32'h3C);
        stall_left = 0;
        rst = 0;
        repeat (2) @(negedge clk);
        run_cycle(1, 0, 20'h0ABCD, 8'h00, 8'h7E, 3);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            miscompares++;
            $display("FAIL watchdog expired: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule